// File: doc/BRIEF.md
# Seconds Counter with Deferred Time Load

This block is the timekeeping core of a real-time clock. It holds a 32-bit count of elapsed seconds and advances it by one on each one-second strobe from an external prescaler. Software sets the time by writing a value through a small register port. That value is not placed in the running counter at once. It is held in a staging register and copied into the counter at the next second strobe, so the counter only ever changes on a second boundary.

The staged value can still be read on its own after the copy. The register port also returns the live sub-second prescaler count, and it stores two control bits for battery switch-over and oscillator enable, which are kept here but drive nothing. Each time the count changes, by increment or by load, the block raises a one-cycle seconds event for the interrupt logic.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the current time, the staged time and the control bits all read as zero, no load is pending and the seconds event is low.
- R2: With no load pending, each cycle with `sec_strobe` high adds one to the current time, which is read at offset 0x10.
- R3: The current time wraps from 0xFFFFFFFF to 0x00000000 on an increment.
- R4: A write to offset 0x00 leaves the current time unchanged until the next strobe, and the current time never changes in a cycle without a strobe.
- R5: At the first strobe after a write to offset 0x00, the current time takes exactly the written value and is not incremented.
- R6: The load clears the pending state, so the strobe after it increments from the loaded value.
- R7: A second write to offset 0x00 before the strobe replaces the pending value, and only the last value is loaded.
- R8: Offset 0x04 returns the last value written to offset 0x00, both before and after it is loaded. A read of offset 0x00 returns zero.
- R9: Offset 0x14 returns `tick_count` in bits 15:0, with bits 31:16 zero.
- R10: Offset 0x40 stores bit 31 (battery switch enable) and bit 24 (oscillator enable) on write and returns them on read. Every other bit of offset 0x40 reads zero.
- R11: `sec_event` is high for exactly the one cycle after a cycle with `sec_strobe` high, which is the cycle in which the new count is first visible. It is low at all other times.
- R12: When a write to offset 0x00 and a strobe happen in the same cycle, the strobe acts on the state from before the write: it loads any value already pending, or otherwise increments. The new value then stays pending for the following strobe.
- R13: Writes to offsets 0x04, 0x10, 0x14 and to any unmapped offset change neither the current time, nor the staged time, nor the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rdata | output | 32 | Read data for the register at `addr` (combinational) |
| sec_strobe | input | 1 | One-cycle pulse from the prescaler marking each second |
| tick_count | input | 16 | Live sub-second prescaler count |
| sec_event | output | 1 | One-cycle pulse when the seconds count updates |

## Verification
The hardest case to reach is a set-time write landing in the same cycle as the strobe. It matters most when a load is already pending, because the old staged value must be loaded while the new one stays staged. The bench drives the write and the strobe from one task that can assert both in the same cycle. It steps that task through directed sequences and then through a long pseudo-random mix of writes, strobes and idle cycles. A bench model of the staging and counting rules predicts every register after each step, and the wrap case is reached by loading 0xFFFFFFFE.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_LOAD_WR = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LOAD_RD = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_NOW     = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_TICK    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h40;

    localparam int unsigned BATT_BIT = 31;
    localparam int unsigned OSC_BIT  = 24;
endpackage

// File: rtl/rtc_load_stage.sv
module rtc_load_stage #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] staged,
    output logic              pending
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              pend;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.pend = 1'b0;
        end
        if (wr_load) begin
            st_d.val  = wdata;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign staged  = st_q.val;
    assign pending = st_q.pend;

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (pending && staged == $past(wdata)));

    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_load && !take) |=> ($stable(staged) && $stable(pending)));

    p_take_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_load) |=> !pending);
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              load_pend,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              evt
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              evt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.evt = strobe;
        if (strobe) begin
            if (load_pend) begin
                c_d.cnt = load_val;
            end else begin
                c_d.cnt = c_q.cnt + DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.cnt;
    assign evt   = c_q.evt;

    p_increment_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load_pend) |=> (count == $past(count) + DATA_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(count));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && load_pend) |=> (count == $past(load_val)));

    p_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> evt);

    p_event_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !evt);
endmodule

// File: rtl/rtc_ctrl_store.sv
module rtc_ctrl_store #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BATT_POS = 31,
    parameter int unsigned OSC_POS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << BATT_POS) | (DATA_W'(1) << OSC_POS);

    logic [DATA_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

    p_ctrl_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl));

    p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctrl[BATT_POS] == $past(wdata[BATT_POS]) &&
                ctrl[OSC_POS]  == $past(wdata[OSC_POS])));
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_sec_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              sec_strobe,
    input  logic [TICK_W-1:0] tick_count,
    output logic              sec_event
);
    localparam int unsigned PAD_W = DATA_W - TICK_W;

    logic              wr_load, wr_ctrl;
    logic [DATA_W-1:0] staged, count, ctrl;
    logic              pending;

    always_comb begin
        wr_load = wr_en && (addr == OFF_LOAD_WR);
        wr_ctrl = wr_en && (addr == OFF_CTRL);
    end

    rtc_load_stage #(.DATA_W(DATA_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_load (wr_load),
        .wdata   (wdata),
        .take    (sec_strobe),
        .staged  (staged),
        .pending (pending)
    );

    rtc_sec_count #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (sec_strobe),
        .load_pend (pending),
        .load_val  (staged),
        .count     (count),
        .evt       (sec_event)
    );

    rtc_ctrl_store #(
        .DATA_W   (DATA_W),
        .BATT_POS (BATT_BIT),
        .OSC_POS  (OSC_BIT)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctrl),
        .wdata (wdata),
        .ctrl  (ctrl)
    );

    always_comb begin
        unique case (addr)
            OFF_LOAD_RD: rdata = staged;
            OFF_NOW:     rdata = count;
            OFF_TICK:    rdata = {{PAD_W{1'b0}}, tick_count};
            OFF_CTRL:    rdata = ctrl;
            default:     rdata = '0;
        endcase
    end

    p_pending_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_strobe && pending && wr_load) |=> (count == $past(staged) && pending));
endmodule

// File: tb/rtc_seconds_core_test.sv
module rtc_seconds_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wr_en;
    logic [31:0] rdata;
    logic        sec_strobe;
    logic [15:0] tick_count;
    logic        sec_event;

    always #5 clk = ~clk;

    rtc_seconds_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .rdata      (rdata),
        .sec_strobe (sec_strobe),
        .tick_count (tick_count),
        .sec_event  (sec_event)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_cnt, m_stage, m_ctrl;
    logic        m_pend;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(8'h10, v); chk(req, "current time", v, m_cnt);
        rd(8'h04, v); chk(req, "staged time", v, m_stage);
        rd(8'h40, v); chk(req, "control", v, m_ctrl);
        rd(8'h00, v); chk(req, "set-time read", v, 32'h0);
    endtask

    task automatic step(input string req, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit s);
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; sec_strobe = s;
        @(negedge clk);
        wr_en = 1'b0; sec_strobe = 1'b0;
        if (s) begin
            if (m_pend) begin
                m_cnt  = m_stage;
                m_pend = 1'b0;
            end else begin
                m_cnt = m_cnt + 32'd1;
            end
        end
        if (w && a == 8'h00) begin
            m_stage = d;
            m_pend  = 1'b1;
        end
        if (w && a == 8'h40) m_ctrl = d & 32'h8100_0000;
        chk("R11", "sec_event", {31'd0, sec_event}, {31'd0, s});
        check_all(req);
        if (s) begin
            @(negedge clk);
            chk("R11", "sec_event after pulse", {31'd0, sec_event}, 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; addr = 8'h00; wdata = '0; wr_en = 1'b0;
        sec_strobe = 1'b0; tick_count = '0;
        m_cnt = '0; m_stage = '0; m_ctrl = '0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        chk("R1", "sec_event", {31'd0, sec_event}, 32'd0);

        // R2 plain increments
        for (int i = 0; i < 20; i++) step("R2", 1'b0, 8'h10, '0, 1'b1);

        // R4 write held back, R5 load at strobe, R6 increment afterwards
        step("R4", 1'b1, 8'h00, 32'h6000_0000, 1'b0);
        for (int i = 0; i < 4; i++) step("R4", 1'b0, 8'h10, '0, 1'b0);
        step("R5", 1'b0, 8'h10, '0, 1'b1);
        step("R6", 1'b0, 8'h10, '0, 1'b1);
        step("R8", 1'b0, 8'h10, '0, 1'b0);

        // R7 second write replaces pending value
        step("R7", 1'b1, 8'h00, 32'hAAAA_0001, 1'b0);
        step("R7", 1'b1, 8'h00, 32'h5555_0002, 1'b0);
        step("R7", 1'b0, 8'h10, '0, 1'b1);

        // R3 wrap
        step("R3", 1'b1, 8'h00, 32'hFFFF_FFFE, 1'b0);
        for (int i = 0; i < 3; i++) step("R3", 1'b0, 8'h10, '0, 1'b1);

        // R12 write coinciding with strobe
        step("R12", 1'b1, 8'h00, 32'h0000_1000, 1'b1);
        step("R12", 1'b1, 8'h00, 32'h0000_2000, 1'b1);
        step("R12", 1'b0, 8'h10, '0, 1'b1);

        // R10 control bits
        step("R10", 1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0);
        step("R10", 1'b1, 8'h40, 32'h0100_0000, 1'b0);
        step("R10", 1'b1, 8'h40, 32'h8000_0000, 1'b0);

        // R13 writes elsewhere are ignored
        step("R13", 1'b1, 8'h04, 32'hDEAD_BEEF, 1'b0);
        step("R13", 1'b1, 8'h10, 32'hDEAD_BEEF, 1'b0);
        step("R13", 1'b1, 8'h14, 32'hDEAD_BEEF, 1'b0);
        step("R13", 1'b1, 8'h20, 32'hDEAD_BEEF, 1'b0);
        step("R13", 1'b1, 8'h44, 32'hDEAD_BEEF, 1'b1);

        // R9 tick sweep
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            tick_count = 16'(k * 257);
            rd(8'h14, v);
            chk("R9", "tick", v, {16'h0, 16'(k * 257)});
        end
        tick_count = 16'hFFFF;
        rd(8'h14, v);
        chk("R9", "tick max", v, 32'h0000_FFFF);

        // mixed sweep across all operations
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            case (lcg[31:29])
                3'd0, 3'd1: a = 8'h00;
                3'd2:       a = 8'h40;
                3'd3:       a = 8'h10;
                default:    a = 8'h04;
            endcase
            step("R12", lcg[28], a, lcg ^ {lcg[15:0], lcg[31:16]}, lcg[27] | lcg[26]);
        end

        finish_run();
    end
endmodule